// File: doc/BRIEF.md
# Memory-based interrupt report writer

The block collects interrupt events from up to 64 units, each presenting a 16-bit event vector tagged with an engine instance. It does not set a status register. It reports each event as bytes written into a report page in memory. Every enabled event bit becomes one byte of 0xFF in the unit's 16-byte status slot. After all of a unit's status bytes are written, one byte of 0xFF marks the unit in the source region. Once memory has acknowledged every write of a pass, the block pulses a single interrupt line to the host.

Events are held in a pending vector for each (instance, unit) pair, and new events are ORed into it. Idle time ends when any pending bit is set and the page base is legal. A pass first reads a 16-bit enable word from the page. It then scans all pending entries in index order (instance-major, unit-minor). For each entry it writes the enabled bits in ascending bit order and then the source byte. In multi-page mode each engine instance has its own 4 KiB page. In single mode all instances share the page at the base.

Top module: `mem_irq_reporter`

## Requirements
- R1: For a reported entry of unit u with enabled bit b, one write of data 0xFF goes to page + u*16 + b. Status writes of one entry go out in ascending b.
- R2: After the last status byte of an entry, exactly one write of 0xFF goes to page + 0x400 + u. In multi-page mode no status byte of that (page, unit) follows it within the same pass.
- R3: Each pass starts with a read request at base + 0x440, held until acknowledged. The 16-bit word returned is the enable mask for the whole pass. Event bits whose mask bit is 0 produce no write and are discarded.
- R4: With cfg_multi=1 the page of instance i is base + i*0x1000. With cfg_multi=0 every instance writes into the page at base.
- R5: irq is a one-cycle pulse, raised only after every accepted write of the pass has been acknowledged. A pass that made no write raises no irq.
- R6: An event that arrives while a pass is running is not lost. It is reported in the current pass or in a later one.
- R7: cfg_err is high whenever cfg_base[11:0] is non-zero, which is the case when the status base is not 4 KiB aligned or the source base is not 64-byte aligned. While it is high no pass starts, and pending events wait.
- R8: A write request with wr_valid high and wr_ready low stays asserted with an unchanged address in the next cycle.
- R9: After reset, wr_valid, mrd_req and irq are low and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Event strobe for one cycle |
| ev_inst | input | IW | Engine instance of the event |
| ev_unit | input | UW | Unit index of the event |
| ev_bits | input | EVT_W | Event vector, ORed into pending |
| cfg_base | input | AW | Byte address of page 0 |
| cfg_multi | input | 1 | 1: one page per instance; 0: shared page |
| cfg_err | output | 1 | Base alignment violation |
| wr_valid | output | 1 | Byte write request |
| wr_ready | input | 1 | Write request accepted this cycle |
| wr_addr | output | AW | Byte address of the write |
| wr_data | output | 8 | Write data (0xFF) |
| wr_ack | input | 1 | One accepted write has completed |
| mrd_req | output | 1 | Enable mask read request |
| mrd_addr | output | AW | Address of the enable word |
| mrd_ack | input | 1 | Mask data valid, request done |
| mrd_data | input | EVT_W | Enable mask word |
| irq | output | 1 | Host interrupt pulse |

## Verification
The bench builds the block with 8 units and 2 instances. That makes a pass scan only 16 entries, so randomly timed events often land in the middle of a pass, both on entries already visited and on entries still ahead of the scan. With two instances, both page layouts can be seen: separate pages in multi-page mode and writes merged into page 0 in single mode. Random ready and acknowledge delays make the block stall on requests and wait for acknowledges before the interrupt.

// File: rtl/mem_irq_reporter.sv
module mem_irq_reporter #(
  parameter int NUM_UNITS = 64,
  parameter int NUM_INST  = 4,
  parameter int EVT_W     = 16,
  parameter int AW        = 32,
  parameter int OUTW      = 16,
  localparam int UW   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int IW   = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [IW-1:0]    ev_inst,
  input  logic [UW-1:0]    ev_unit,
  input  logic [EVT_W-1:0] ev_bits,
  input  logic [AW-1:0]    cfg_base,
  input  logic             cfg_multi,
  output logic             cfg_err,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [AW-1:0]    wr_addr,
  output logic [7:0]       wr_data,
  input  logic             wr_ack,
  output logic             mrd_req,
  output logic [AW-1:0]    mrd_addr,
  input  logic             mrd_ack,
  input  logic [EVT_W-1:0] mrd_data,
  output logic             irq
);

  localparam int NENT     = NUM_INST * NUM_UNITS;
  localparam int EW       = (NENT > 1) ? $clog2(NENT) : 1;
  localparam int BW       = (EVT_W > 1) ? $clog2(EVT_W) : 1;
  localparam int PAGE_SH  = 12;
  localparam int SRC_OFF  = 'h400;
  localparam int MASK_OFF = 'h440;

  typedef enum logic [2:0] {S_IDLE, S_MASK, S_SCAN, S_STAT, S_SRC, S_DRAIN} st_t;

  st_t              st;
  logic [EVT_W-1:0] pend [NENT];
  logic [EVT_W-1:0] mask, cur, sel, cur_next;
  logic [EW-1:0]    idx, ev_idx, idx_inst, idx_unit;
  logic [BW-1:0]    bitpos;
  logic [AW-1:0]    page;
  logic [OUTW-1:0]  outst;
  logic             wrote, pend_any, last, accept;

  function automatic logic [BW-1:0] lowbit(input logic [EVT_W-1:0] v);
    lowbit = '0;
    for (int i = EVT_W - 1; i >= 0; i--)
      if (v[i]) lowbit = BW'(i);
  endfunction

  assign cfg_err  = (cfg_base[PAGE_SH-1:0] != '0);
  assign ev_idx   = EW'(ev_inst) * EW'(NUM_UNITS) + EW'(ev_unit);
  assign idx_inst = idx / EW'(NUM_UNITS);
  assign idx_unit = idx % EW'(NUM_UNITS);
  assign page     = cfg_base + ((cfg_multi ? AW'(idx_inst) : AW'(0)) << PAGE_SH);
  assign bitpos   = lowbit(cur);
  assign cur_next = cur & ~(EVT_W'(1) << bitpos);
  assign sel      = pend[idx] & mask;
  assign last     = (idx == EW'(NENT - 1));

  assign mrd_req  = (st == S_MASK);
  assign mrd_addr = cfg_base + AW'(MASK_OFF);
  assign wr_valid = (st == S_STAT) || (st == S_SRC);
  assign wr_data  = 8'hFF;
  assign wr_addr  = (st == S_SRC) ? page + AW'(SRC_OFF) + AW'(idx_unit)
                                  : page + AW'(idx_unit) * AW'(EVT_W) + AW'(bitpos);
  assign accept   = wr_valid && wr_ready;

  always_comb begin
    pend_any = 1'b0;
    for (int i = 0; i < NENT; i++) pend_any = pend_any | (pend[i] != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) pend[i] <= '0;
    end else begin
      for (int i = 0; i < NENT; i++) begin
        if (st == S_SCAN && idx == EW'(i))
          pend[i] <= (ev_valid && ev_idx == EW'(i)) ? ev_bits : '0;
        else if (ev_valid && ev_idx == EW'(i))
          pend[i] <= pend[i] | ev_bits;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      mask  <= '0;
      cur   <= '0;
      idx   <= '0;
      wrote <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (st)
        S_IDLE:  if (pend_any && !cfg_err) st <= S_MASK;
        S_MASK:  if (mrd_ack) begin
                   mask  <= mrd_data;
                   idx   <= '0;
                   wrote <= 1'b0;
                   st    <= S_SCAN;
                 end
        S_SCAN:  if (sel != '0) begin
                   cur <= sel;
                   st  <= S_STAT;
                 end else if (last) begin
                   st <= wrote ? S_DRAIN : S_IDLE;
                 end else begin
                   idx <= idx + 1'b1;
                 end
        S_STAT:  if (wr_ready) begin
                   cur   <= cur_next;
                   wrote <= 1'b1;
                   if (cur_next == '0) st <= S_SRC;
                 end
        S_SRC:   if (wr_ready) begin
                   if (last) st <= S_DRAIN;
                   else begin
                     idx <= idx + 1'b1;
                     st  <= S_SCAN;
                   end
                 end
        S_DRAIN: if (outst == '0) begin
                   irq <= 1'b1;
                   st  <= S_IDLE;
                 end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= '0;
    else begin
      case ({accept, wr_ack})
        2'b10:   outst <= outst + 1'b1;
        2'b01:   outst <= outst - 1'b1;
        default: outst <= outst;
      endcase
    end
  end

  assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr)));

  assert_data_ff_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data == 8'hFF));

  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_req && !mrd_ack) |=> mrd_req);

  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_drained_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (outst == '0 && !wr_valid));

  assert_ack_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |-> (outst != '0));

  assert_no_start_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cfg_err) |=> (st == S_IDLE));

endmodule

// File: tb/mem_irq_reporter_bench.sv
`timescale 1ns/1ps
module mem_irq_reporter_bench;
  localparam int NU = 8;
  localparam int NI = 2;
  localparam int EW = 16;
  localparam int AW = 32;
  localparam logic [31:0] BASE = 32'h0004_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic [0:0] ev_inst = '0;
  logic [2:0] ev_unit = '0;
  logic [EW-1:0] ev_bits = '0;
  logic [AW-1:0] cur_base = BASE;
  logic multi = 1'b1;
  logic cfg_err, wr_valid, wr_ready = 1'b0, wr_ack = 1'b0;
  logic [AW-1:0] wr_addr, mrd_addr;
  logic [7:0] wr_data;
  logic mrd_req, mrd_ack = 1'b0, irq;
  logic [EW-1:0] mrd_data = '0;

  logic [EW-1:0] exp_stat [NI][NU];
  logic [EW-1:0] got_stat [NI][NU];
  logic exp_src [NI][NU];
  logic got_src [NI][NU];
  logic src_pass [NI][NU];
  logic [EW-1:0] mask_val = 16'hFFFF;
  int checks = 0, fails = 0, irq_cnt = 0, acc_pending = 0, quiet = 0;
  logic stall_prev = 1'b0;
  logic [AW-1:0] addr_prev = '0;

  always #4 clk = ~clk;

  mem_irq_reporter #(.NUM_UNITS(NU), .NUM_INST(NI), .EVT_W(EW), .AW(AW), .OUTW(16)) u_mem_irq_reporter (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_inst(ev_inst), .ev_unit(ev_unit),
    .ev_bits(ev_bits), .cfg_base(cur_base), .cfg_multi(multi), .cfg_err(cfg_err),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ack(wr_ack), .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_ack(mrd_ack),
    .mrd_data(mrd_data), .irq(irq));

  task automatic fail_msg(input string req, input string what, input longint act, input longint expv);
    fails++;
    $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
  endtask

  task automatic check(input string req, input string what, input longint act, input longint expv);
    checks++;
    if (act != expv) fail_msg(req, what, act, expv);
  endtask

  task automatic clear_books();
    for (int p = 0; p < NI; p++)
      for (int u = 0; u < NU; u++) begin
        exp_stat[p][u] = '0; got_stat[p][u] = '0;
        exp_src[p][u] = 1'b0; got_src[p][u] = 1'b0; src_pass[p][u] = 1'b0;
      end
    irq_cnt = 0;
  endtask

  task automatic record_write();
    logic [AW-1:0] off;
    int p, io;
    off = wr_addr - cur_base;
    p = int'(off >> 12);
    io = int'(off[11:0]);
    check("R1", "write data", wr_data, 8'hFF);
    if (p >= NI) fail_msg("R4", "page out of range", wr_addr, cur_base);
    else if (io < NU * 16) begin
      checks++;
      if (multi && src_pass[p][io >> 4]) fail_msg("R2", "status after source", wr_addr, 0);
      got_stat[p][io >> 4][io & 15] = 1'b1;
    end else if (io >= 'h400 && io < 'h400 + NU) begin
      got_src[p][io - 'h400] = 1'b1;
      src_pass[p][io - 'h400] = 1'b1;
    end else fail_msg("R4", "address outside regions", wr_addr, cur_base);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) begin
        check("R8", "held valid", wr_valid, 1);
        check("R8", "held address", wr_addr, addr_prev);
      end
      if (irq) begin
        irq_cnt++;
        check("R5", "acks outstanding at irq", acc_pending, 0);
        for (int p = 0; p < NI; p++)
          for (int u = 0; u < NU; u++) src_pass[p][u] = 1'b0;
      end
      if (acc_pending > 0 && ($urandom % 3) != 0) begin
        wr_ack = 1'b1;
        acc_pending--;
      end else wr_ack = 1'b0;
      if (mrd_req && !mrd_ack && ($urandom % 2) == 0) begin
        check("R3", "mask address", mrd_addr, cur_base + 32'h440);
        mrd_ack = 1'b1;
        mrd_data = mask_val;
      end else mrd_ack = 1'b0;
      wr_ready = (($urandom % 10) < 7);
      if (wr_valid && wr_ready) begin
        record_write();
        acc_pending++;
      end
      stall_prev = wr_valid && !wr_ready;
      addr_prev = wr_addr;
      if (wr_valid || mrd_req || acc_pending != 0 || irq) quiet = 0;
      else quiet++;
    end
  end

  task automatic send(input int inst, input int unit, input logic [EW-1:0] bits);
    int p;
    @(negedge clk);
    ev_valid = 1'b1;
    ev_inst = 1'(inst);
    ev_unit = 3'(unit);
    ev_bits = bits;
    p = multi ? inst : 0;
    exp_stat[p][unit] |= (bits & mask_val);
    if ((bits & mask_val) != '0) exp_src[p][unit] = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic settle_and_compare(input string req);
    logic any;
    any = 1'b0;
    quiet = 0;
    while (quiet < 40) @(negedge clk);
    for (int p = 0; p < NI; p++)
      for (int u = 0; u < NU; u++) begin
        check(req, $sformatf("status page %0d unit %0d", p, u), got_stat[p][u], exp_stat[p][u]);
        check(req, $sformatf("source page %0d unit %0d", p, u), got_src[p][u], exp_src[p][u]);
        if (exp_src[p][u]) any = 1'b1;
      end
    checks++;
    if (any && irq_cnt == 0) fail_msg("R5", "missing irq", irq_cnt, 1);
    if (!any && irq_cnt != 0) fail_msg("R5", "irq without writes", irq_cnt, 0);
    clear_books();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fail_msg("R5", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int act;
    void'($urandom(32'd4711));
    clear_books();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "wr_valid after reset", wr_valid, 0);
    check("R9", "mrd_req after reset", mrd_req, 0);
    check("R9", "irq after reset", irq, 0);
    check("R7", "cfg_err aligned base", cfg_err, 0);
    repeat (10) @(negedge clk);
    check("R9", "no pass without events", mrd_req, 0);

    multi = 1'b1; mask_val = 16'hFFFF;
    send(1, 3, 16'h8001);
    send(0, 0, 16'h0001);
    settle_and_compare("R1 R2 R4");

    multi = 1'b0;
    send(1, 7, 16'h00F0);
    send(0, 7, 16'h0F00);
    settle_and_compare("R4");

    multi = 1'b1; mask_val = 16'h00FF;
    send(0, 2, 16'hFF00);
    settle_and_compare("R3");
    mask_val = 16'hFFFF;
    send(0, 1, 16'h0001);
    settle_and_compare("R3");
    mask_val = 16'h0000;
    send(1, 4, 16'hFFFF);
    settle_and_compare("R3");

    mask_val = 16'hFFFF;
    send(0, 0, 16'h000F);
    while (!wr_valid) @(negedge clk);
    send(0, 0, 16'h0030);
    send(1, 5, 16'h0100);
    settle_and_compare("R6");

    @(negedge clk);
    cur_base = BASE + 32'h40;
    #1 check("R7", "cfg_err 64-aligned base", cfg_err, 1);
    cur_base = BASE + 32'h810;
    #1 check("R7", "cfg_err unaligned base", cfg_err, 1);
    send(1, 6, 16'h0202);
    act = 0;
    repeat (50) begin
      @(negedge clk);
      if (wr_valid || mrd_req) act++;
    end
    check("R7", "activity while misaligned", act, 0);
    cur_base = BASE;
    #1 check("R7", "cfg_err cleared", cfg_err, 0);
    settle_and_compare("R7");

    for (int e = 0; e < 40; e++) begin
      int n, sel;
      multi = 1'($urandom % 2);
      sel = int'($urandom % 4);
      mask_val = (sel < 2) ? 16'hFFFF : (sel == 2) ? 16'($urandom) : (16'($urandom) & 16'h0F0F);
      n = 1 + int'($urandom % 5);
      for (int k = 0; k < n; k++) begin
        send(int'($urandom % NI), int'($urandom % NU), 16'($urandom) & 16'($urandom));
        repeat (int'($urandom % 20)) @(negedge clk);
      end
      settle_and_compare("R1 R2 R6");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule